// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

This block is a synthesizable model of a synchronous SRAM whose read and write cycles share one pipeline of fixed depth, so that the data bus can move straight from a read to a write, or from a write to a read, with no idle cycle. Each enabled rising clock edge takes one command. The command comes from two chip selects, a load/advance strobe, a read/write select and four active-low byte write enables. Read data and write data both use the data phase two enabled edges after the command. The bidirectional data bus is split into `dq_in`, `dq_out` and a drive enable `dq_oe`. The pad-level tri-state is left to the surrounding logic.

A load cycle starts a burst at an external address. Continue cycles step a two-bit burst counter through the aligned group of four words, and they keep the direction chosen at the load. A burst controller tracks one of three states: `BST_DESEL`, `BST_READ` and `BST_WRITE`. Its transitions are:
- `load_read`: a selected load with read/write high goes to `BST_READ`.
- `load_write`: a selected load with read/write low goes to `BST_WRITE`.
- `deselect`: an unselected load goes to `BST_DESEL`.
- `continue`: an advance keeps the current state. In `BST_DESEL` it issues nothing.

A high clock-enable input freezes the whole block for that cycle.

Top module: `zbt_burst_sram`

## Requirements
- R1: The device is selected only when `ce0_n`=0 and `ce1`=1. A load cycle with any other combination is a deselect, and `dq_oe` stays 0 in that cycle's data phase.
- R2: A cycle with `adv_ld`=0 and the device selected loads `addr`. With `rw`=1 it issues a read of that word, and with `rw`=0 it issues a write to that word.
- R3: A cycle with `adv_ld`=1 inside an active burst repeats the direction of the last load, whatever the value of `rw`.
- R4: Each continue cycle adds one, modulo 4, to the low two address bits, starting from the loaded address. The upper address bits stay fixed, so the fourth burst word is followed by the loaded address again.
- R5: A continue cycle issues nothing after reset or after a deselect.
- R6: During a write data phase, lane i (`dq_in[8i+7:8i]`) is stored only if `bw_n[i]` was 0 in that write's command cycle.
- R7: A write whose four `bw_n` bits were all 1 in its command cycle leaves the memory unchanged.
- R8: Read data is presented on `dq_out` in the data phase, which is the cycle after the second enabled edge following the command. Write data is sampled at the edge that ends the write's data phase. Reads and writes may alternate on consecutive cycles, and a read always returns the latest data written to its word, including a write issued one cycle earlier.
- R9: While `cen_n`=1 no command is taken, no memory write happens, the burst address is held, and `dq_out` and the pipeline keep their values.
- R10: `dq_oe` is 0 during every write data phase whatever `oe_n` is. During a read data phase `dq_oe` equals the inverse of `oe_n`, so a read with `oe_n`=1 is a dummy read.
- R11: While reset is asserted, and after it is released, the burst state is deselected and `dq_oe` is 0 until a read reaches its data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oe_n` are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Clock enable, active low; 1 inserts a wait state |
| ce0_n | input | 1 | Chip select, active low |
| ce1 | input | 1 | Chip select, active high |
| adv_ld | input | 1 | 0 = load a new address, 1 = advance the burst |
| rw | input | 1 | Direction on load cycles: 1 = read, 0 = write |
| bw_n | input | 4 | Active-low byte write enables, one per lane |
| oe_n | input | 1 | Active-low output enable for read data phases |
| addr | input | 8 | Word address |
| dq_in | input | 32 | Write data |
| dq_out | output | 32 | Read data |
| dq_oe | output | 1 | Drive enable for `dq_out` |

## Verification
The hardest case to reach from the ports is a read whose data phase directly follows a write to the same word. In that cycle the stored word is stale and the value must come from the write data on the bus in that same cycle. Directed bursts force this case by alternating write and read to one address, and random stimulus hits it again by reusing addresses from a small set. Wraparound from every start offset and continue cycles that arrive after a deselect are also reached on purpose. Wait states are sprinkled inside bursts so that a stalled write data phase and a stalled read data phase both occur.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    typedef enum logic [1:0] {
        BST_DESEL = 2'd0,
        BST_READ  = 2'd1,
        BST_WRITE = 2'd2
    } burst_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/zbt_burst_ctl.sv
module zbt_burst_ctl
    import zbt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int LANES     = 4,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              adv_ld,
    input  logic              rw,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LANES-1:0]  cmd_mask
);
    localparam int BURST_W = $clog2(BURST_LEN);

    burst_state_e             state, state_nxt;
    logic [ADDR_W-1:0]        base, base_nxt;
    logic [BURST_W-1:0]       off, off_nxt;
    logic                     selected;
    logic [BURST_W-1:0]       off_inc;

    assign selected = !ce0_n && ce1;
    assign off_inc  = off + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BST_DESEL;
            base  <= '0;
            off   <= '0;
        end else if (step_en) begin
            state <= state_nxt;
            base  <= base_nxt;
            off   <= off_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        base_nxt  = base;
        off_nxt   = off;
        if (!adv_ld) begin
            base_nxt = addr;
            off_nxt  = '0;
            if (!selected)
                state_nxt = BST_DESEL;
            else if (rw)
                state_nxt = BST_READ;
            else
                state_nxt = BST_WRITE;
        end else begin
            unique case (state)
                BST_DESEL: off_nxt = off;
                BST_READ:  off_nxt = off_inc;
                BST_WRITE: off_nxt = off_inc;
                default:   off_nxt = off;
            endcase
        end
    end

    // command outputs
    always_comb begin
        cmd_op   = OP_NONE;
        cmd_addr = {base[ADDR_W-1:BURST_W], base[BURST_W-1:0] + off_inc};
        cmd_mask = '0;
        if (!adv_ld) begin
            cmd_addr = addr;
            if (selected) begin
                cmd_op   = rw ? OP_READ : OP_WRITE;
                cmd_mask = rw ? '0 : ~bw_n;
            end
        end else begin
            unique case (state)
                BST_DESEL: cmd_op = OP_NONE;
                BST_READ:  cmd_op = OP_READ;
                BST_WRITE: begin
                    cmd_op   = OP_WRITE;
                    cmd_mask = ~bw_n;
                end
                default:   cmd_op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g])
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/zbt_data_pipe.sv
module zbt_data_pipe
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_en,
    input  op_e                     in_op,
    input  logic [ADDR_W-1:0]       in_addr,
    input  logic [LANES-1:0]        in_mask,
    input  logic [LANES*LANE_W-1:0] dq_in,
    input  logic [LANES*LANE_W-1:0] arr_rdata,
    output logic [ADDR_W-1:0]       arr_raddr,
    output logic [LANES-1:0]        arr_we,
    output logic [ADDR_W-1:0]       arr_waddr,
    output logic [LANES*LANE_W-1:0] arr_wdata,
    output logic [LANES*LANE_W-1:0] rd_word,
    output logic                    s2_read
);
    localparam int DATA_W = LANES * LANE_W;

    op_e               s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s1_mask, s2_mask;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] fwd_word;
    logic              fwd_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_op   <= OP_NONE;
            s1_addr <= '0;
            s1_mask <= '0;
            s2_op   <= OP_NONE;
            s2_addr <= '0;
            s2_mask <= '0;
            rd_q    <= '0;
        end else if (step_en) begin
            s1_op   <= in_op;
            s1_addr <= in_addr;
            s1_mask <= in_mask;
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_mask <= s1_mask;
            if (s1_op == OP_READ)
                rd_q <= fwd_word;
        end
    end

    // a write in its data phase lands at the same edge that captures the read
    assign fwd_hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign fwd_word[g*LANE_W +: LANE_W] = (fwd_hit && s2_mask[g])
                                            ? dq_in[g*LANE_W +: LANE_W]
                                            : arr_rdata[g*LANE_W +: LANE_W];
        assign arr_we[g] = step_en && (s2_op == OP_WRITE) && s2_mask[g];
    end

    assign arr_raddr = s1_addr;
    assign arr_waddr = s2_addr;
    assign arr_wdata = dq_in;
    assign rd_word   = rd_q;
    assign s2_read   = (s2_op == OP_READ);

endmodule

// File: rtl/zbt_burst_sram.sv
module zbt_burst_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int LANES     = 4,
    parameter int LANE_W    = 8,
    parameter int BURST_LEN = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cen_n,
    input  logic                    ce0_n,
    input  logic                    ce1,
    input  logic                    adv_ld,
    input  logic                    rw,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);
    localparam int DATA_W = LANES * LANE_W;

    logic              step_en;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LANES-1:0]  cmd_mask;
    logic [ADDR_W-1:0] arr_raddr, arr_waddr;
    logic [LANES-1:0]  arr_we;
    logic [DATA_W-1:0] arr_wdata, arr_rdata;
    logic              s2_read;

    assign step_en = !cen_n;

    zbt_burst_ctl #(
        .ADDR_W   (ADDR_W),
        .LANES    (LANES),
        .BURST_LEN(BURST_LEN)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .ce0_n   (ce0_n),
        .ce1     (ce1),
        .adv_ld  (adv_ld),
        .rw      (rw),
        .bw_n    (bw_n),
        .addr    (addr),
        .cmd_op  (cmd_op),
        .cmd_addr(cmd_addr),
        .cmd_mask(cmd_mask)
    );

    zbt_data_pipe #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .in_op    (cmd_op),
        .in_addr  (cmd_addr),
        .in_mask  (cmd_mask),
        .dq_in    (dq_in),
        .arr_rdata(arr_rdata),
        .arr_raddr(arr_raddr),
        .arr_we   (arr_we),
        .arr_waddr(arr_waddr),
        .arr_wdata(arr_wdata),
        .rd_word  (dq_out),
        .s2_read  (s2_read)
    );

    zbt_lane_array #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_array (
        .clk  (clk),
        .we   (arr_we),
        .waddr(arr_waddr),
        .wdata(arr_wdata),
        .raddr(arr_raddr),
        .rdata(arr_rdata)
    );

    // drivers only in read data phases, gated by the asynchronous enable
    assign dq_oe = s2_read && !oe_n;

endmodule

// File: rtl/zbt_burst_sram_chk.sv
module zbt_burst_sram_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cen_n,
    input logic              ce0_n,
    input logic              ce1,
    input logic              adv_ld,
    input logic              rw,
    input logic              oe_n,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);
    // shadow of the command type seen at the ports: 0 none, 1 read, 2 write
    logic [1:0] mode_q, issued, ph1, ph2;

    always_comb begin
        if (!adv_ld)
            issued = (!ce0_n && ce1) ? (rw ? 2'd1 : 2'd2) : 2'd0;
        else
            issued = mode_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 2'd0;
            ph1    <= 2'd0;
            ph2    <= 2'd0;
        end else if (!cen_n) begin
            mode_q <= issued;
            ph1    <= issued;
            ph2    <= ph1;
        end
    end

    p_desel_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2 == 2'd0) |-> !dq_oe);

    p_read_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2 == 2'd1 && !oe_n) |-> dq_oe);

    p_dummy_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2 == 2'd1 && oe_n) |-> !dq_oe);

    p_write_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2 == 2'd2) |-> !dq_oe);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(dq_out));

    p_reset_hiz_r11: assert property (@(posedge clk)
        !rst_n |=> !dq_oe);

endmodule

bind zbt_burst_sram zbt_burst_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cen_n (cen_n),
    .ce0_n (ce0_n),
    .ce1   (ce1),
    .adv_ld(adv_ld),
    .rw    (rw),
    .oe_n  (oe_n),
    .dq_out(dq_out),
    .dq_oe (dq_oe)
);

// File: tb/zbt_burst_sram_test.sv
module zbt_burst_sram_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NW = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        cen_n = 1'b1, ce0_n = 1'b1, ce1 = 1'b0, adv_ld = 1'b0, rw = 1'b1, oe_n = 1'b1;
    logic [3:0]  bw_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [31:0] dq_in = '0;
    logic [31:0] dq_out;
    logic        dq_oe;

    int nvec = 0;
    int nfail = 0;

    // reference model state
    int          m_mode = 0;          // 0 deselected, 1 read burst, 2 write burst
    logic [AW-1:0] m_base = '0;
    logic [1:0]  m_off = '0;
    int          p1_k = 0, p2_k = 0;
    logic [AW-1:0] p1_a = '0, p2_a = '0;
    logic [3:0]  p1_m = '0, p2_m = '0;
    logic [31:0] mem_m [NW];
    bit          known [NW];
    logic [31:0] exp_data = '0;
    bit          exp_known = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zbt_burst_sram uut (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce0_n(ce0_n), .ce1(ce1),
        .adv_ld(adv_ld), .rw(rw), .bw_n(bw_n), .oe_n(oe_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [31:0] pattern(input logic [AW-1:0] a);
        return {a ^ 8'h3C, ~a, a + 8'h51, a};
    endfunction

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    task automatic model_edge();
        int          nk;
        logic [AW-1:0] na;
        logic [3:0]  nm;
        if (cen_n) return;                        // R9 wait state: nothing moves
        if (p2_k == 2) begin                      // R6/R7 lane-masked store
            for (int l = 0; l < 4; l++)
                if (p2_m[l]) mem_m[p2_a][l*8 +: 8] = dq_in[l*8 +: 8];
            if (p2_m != 4'hF && p2_m != 4'h0 && !known[p2_a]) known[p2_a] = 1'b0;
            if (p2_m == 4'hF) known[p2_a] = 1'b1;
        end
        nk = 0; na = '0; nm = '0;
        if (!adv_ld) begin
            m_base = addr; m_off = '0;
            if (!ce0_n && ce1) begin
                nk = rw ? 1 : 2; na = addr; nm = rw ? 4'h0 : ~bw_n;
            end
            m_mode = nk;
        end else if (m_mode != 0) begin
            m_off = m_off + 2'd1;
            nk = m_mode;
            na = {m_base[AW-1:2], m_base[1:0] + m_off};
            nm = (m_mode == 2) ? ~bw_n : 4'h0;
        end
        p2_k = p1_k; p2_a = p1_a; p2_m = p1_m;
        p1_k = nk;   p1_a = na;   p1_m = nm;
        if (p2_k == 1) begin
            exp_data  = mem_m[p2_a];
            exp_known = known[p2_a];
        end
    endtask

    task automatic check(input string tag);
        logic exp_oe;
        exp_oe = (p2_k == 1) && !oe_n;
        nvec++;
        if (dq_oe !== exp_oe) begin
            nfail++;
            $display("FAIL %s dq_oe got %0b expected %0b", tag, dq_oe, exp_oe);
        end
        if (exp_oe && exp_known) begin
            nvec++;
            if (dq_out !== exp_data) begin
                nfail++;
                $display("FAIL %s dq_out got %h expected %h", tag, dq_out, exp_data);
            end
        end
    endtask

    task automatic step(input logic cen, input logic c0, input logic c1, input logic adv,
                        input logic rwi, input logic [3:0] bw, input logic oe,
                        input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        cen_n = cen; ce0_n = c0; ce1 = c1; adv_ld = adv; rw = rwi;
        bw_n = bw; oe_n = oe; addr = a; dq_in = d;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    task automatic nop(input string tag);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 1'b0, '0, '0, tag);
    endtask

    // load a 4-beat burst, continue cycles flip rw to show it is ignored
    task automatic burst(input logic rd, input logic [AW-1:0] a, input logic [3:0] bw,
                         input string tag);
        logic [AW-1:0] w;
        step(1'b0, 1'b0, 1'b1, 1'b0, rd, bw, 1'b0, a, pattern(a), tag);
        for (int i = 1; i < 4; i++) begin
            w = {a[AW-1:2], a[1:0] + 2'(i)};
            step(1'b0, 1'b0, 1'b1, 1'b1, ~rd, bw, 1'b0, a, pattern(w), tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [AW-1:0] ra;
        logic [3:0] rbw;
        for (int i = 0; i < NW; i++) begin mem_m[i] = '0; known[i] = 1'b0; end
        void'($urandom(32'd20240611));

        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        nvec++;                                   // R11 reset state
        if (dq_oe !== 1'b0) begin
            nfail++; $display("FAIL R11 dq_oe got %0b expected 0", dq_oe);
        end
        rst_n = 1'b1;

        // R5: continue straight after reset issues nothing
        repeat (3) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 1'b0, 8'h10, '0, "R5");
        nop("R5");
        repeat (3) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 1'b0, 8'h10, '0, "R5");

        // R4/R3: fill every word, bursts start mid-group to force wrap
        for (int b = 0; b < NW; b += 4)
            burst(1'b0, 8'(b + 2), 4'h0, "R4");
        nop("R4"); nop("R4");

        // R2/R4/R3 read back with wrap from offsets 3 and 1
        burst(1'b1, 8'h07, 4'h0, "R4");
        burst(1'b1, 8'h21, 4'h0, "R2");
        nop("R2"); nop("R2");

        // R8: alternate write and read of one word, no idle cycle
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 8'h40, 32'hA5A50000 + i, "R8");
            step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 1'b0, 8'h40, 32'h0, "R8");
        end
        nop("R8"); nop("R8");

        // R6: partial lane write then read
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b1010, 1'b0, 8'h09, 32'h11223344, "R6");
        nop("R6");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 8'h09, 32'hDEADBEEF, "R6");
        nop("R6"); nop("R6");

        // R7: write abort leaves the word alone
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 1'b0, 8'h0A, 32'hFFFFFFFF, "R7");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 1'b0, 8'h0A, 32'h0, "R7");
        nop("R7"); nop("R7");

        // R9: wait states inside read and write bursts
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 8'h30, '0, "R9");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, '0, "R9");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, '0, "R9");
        repeat (2) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 8'h00, 32'h55, "R9");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, '0, "R9");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 8'h50, 32'h01020304, "R9");
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 1'b0, 8'h50, 32'h99999999, "R9");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 1'b0, 8'h50, 32'h05060708, "R9");
        repeat (2) step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 1'b0, 8'h50, 32'h77777777, "R9");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 1'b0, 8'h50, 32'h0A0B0C0D, "R9");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 8'h50, 32'h0, "R9");
        nop("R9"); nop("R9");

        // R10: write burst with oe_n low, then dummy read
        burst(1'b0, 8'h60, 4'h0, "R10");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 1'b1, 8'h60, '0, "R10");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 1'b1, 8'h60, '0, "R10");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 1'b1, 8'h60, '0, "R10");
        nop("R10");

        // R1: non-selecting enable combinations, then continue
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 1'b0, 8'h07, '0, "R1");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 1'b0, 8'h07, '0, "R1");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'h0, 1'b0, 8'h07, '0, "R1");
        repeat (3) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 1'b0, 8'h07, '0, "R1");

        // R8 random traffic over a narrow address set
        for (int i = 0; i < 5000; i++) begin
            ra  = 8'($urandom_range(0, 15));
            rbw = ($urandom_range(0, 7) == 0) ? 4'hF : 4'($urandom);
            step(($urandom_range(0, 6) == 0), ($urandom_range(0, 9) == 0),
                 ($urandom_range(0, 9) != 0), ($urandom_range(0, 2) == 0),
                 1'($urandom), rbw, ($urandom_range(0, 4) == 0), ra,
                 $urandom, "R8");
        end

        summary();
        $finish;
    end

endmodule